// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Model

This block is a synthesizable stand-in for an asynchronous static RAM with a 16-bit word and two byte lanes. It is meant for an FPGA test harness. The RAM's control pins are driven from outside without any clock relation to the harness. The block samples them with its own fast clock and decodes the control truth table separately for each byte lane. It drives read data onto the lanes that are selected, and it commits write data when the write strobe ends.

The bidirectional data bus is split into three parts: an input word, an output word, and one output-enable bit per lane, which an outer pad wrapper can turn into tri-state drivers. Every control, address and data input passes through a two-flop synchronizer before it is used. A write counts as active while chip enable and write enable are both low. It commits when the synchronized view of that condition goes away, whichever strobe rose first. The commit uses the address, data and lane selects from the last sampled cycle in which the write was still active. The array depth is 2^ADDR_W words. ADDR_W = 16 gives the full 65,536-word part, and a smaller default keeps elaboration light.

Top module: `bytelane_sram`

## Requirements
- R1: The array holds 2^ADDR_W independent 16-bit words (65,536 with ADDR_W = 16). A word written at one address reads back unchanged after every other address has been written.
- R2: While chip enable (ceN) is high, laneOe is 0 and dataOut is 0, and a write strobe (weN low) leaves the array unchanged.
- R3: Read mode is ceN low, weN high and oeN low. Three rising clock edges after the inputs settle, each selected lane drives the stored byte at addrIn and shows it on dataOut.
- R4: laneOe bit 0 and dataOut[7:0] follow lbN. laneOe bit 1 and dataOut[15:8] follow ubN. A lane whose select is high is not driven and reads as 0.
- R5: In write mode (ceN and weN low) oeN has no effect: a write commits the same way with oeN high or low.
- R6: A write changes only the lanes whose select is low. The other byte of the word keeps its old value.
- R7: While weN is low, laneOe stays 0.
- R8: Output-disable mode (ceN low, weN high, oeN high) gives laneOe = 0.
- R9: With lbN and ubN both high, no lane is driven and a write leaves the word unchanged.
- R10: A write commits when weN rises or, if ceN rises first, when ceN rises. It stores the address, data and selects from the last sample before the write ended. Address or data changes that arrive together with the ending strobe are not stored. A later weN rise with ceN already high commits nothing.
- R11: After reset, laneOe is 0 and dataOut is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | ADDR_W | Word address |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| lbN | input | 1 | Lower byte select (bits 7:0), active low |
| ubN | input | 1 | Upper byte select (bits 15:8), active low |
| dataIn | input | 16 | Write data from the bus |
| dataOut | output | 16 | Read data, zero on undriven lanes |
| laneOe | output | 2 | Per-lane drive enable: bit 0 lower, bit 1 upper |

## Verification
Each input passes through two synchronizer flops and then one output register. A read result is therefore due on the third rising edge after the inputs change. The bench changes inputs on falling edges, waits three rising edges, and samples on the following falling edge. A write commits on the third rising edge after its ending strobe rises. The bench waits four rising edges after every write end before it issues a read, so a commit can never land in the same cycle as the read that checks it. Lane-drive results seen during a write, in standby and in output-disable mode are sampled with the same three-edge delay.

// File: rtl/bytelane_sram_pkg.sv
package bytelane_sram_pkg;

  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 2;
  localparam int DATA_W    = LANE_W * NUM_LANES;

  // Active-low control pins as seen after synchronization.
  // selN bit 0 is the lower lane, bit 1 the upper lane.
  typedef struct packed {
    logic                 ceN;
    logic                 weN;
    logic                 oeN;
    logic [NUM_LANES-1:0] selN;
  } ctl_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 capture;  // write active this cycle: latch addr/data/lanes
    logic                 commit;   // write just ended: store latched word
    logic [NUM_LANES-1:0] capLane;  // lanes selected this cycle
    logic [NUM_LANES-1:0] rdLane;   // lanes to drive next cycle
  } strobe_t;

endpackage

// File: rtl/bytelane_sram_ctrl.sv
module bytelane_sram_ctrl
  import bytelane_sram_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  ctl_t    ctlIn,
  output ctl_t    ctlSync,
  output strobe_t strb
);

  ctl_t stage1;
  ctl_t stage2;
  logic wrPrev;
  logic wrActive;
  logic rdActive;

  // Two-flop synchronizer; reset value is all pins inactive.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '1;
      stage2 <= '1;
    end else begin
      stage1 <= ctlIn;
      stage2 <= stage1;
    end
  end

  assign wrActive = !stage2.ceN && !stage2.weN;
  assign rdActive = !stage2.ceN && stage2.weN && !stage2.oeN;

  always_ff @(posedge clk) begin
    if (!rstN) wrPrev <= 1'b0;
    else       wrPrev <= wrActive;
  end

  always_comb begin
    strb.capture = wrActive;
    strb.commit  = wrPrev && !wrActive;
    strb.capLane = ~stage2.selN;
    strb.rdLane  = rdActive ? ~stage2.selN : '0;
  end

  assign ctlSync = stage2;

endmodule

// File: rtl/bytelane_sram_dp.sv
module bytelane_sram_dp
  import bytelane_sram_pkg::*;
#(
  parameter int ADDR_W = 10
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [DATA_W-1:0]    dataIn,
  input  strobe_t              strb,
  output logic [DATA_W-1:0]    dataOut,
  output logic [NUM_LANES-1:0] laneOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0]    addrS1, addrS2, capAddr;
  logic [DATA_W-1:0]    dataS1, dataS2, capData;
  logic [NUM_LANES-1:0] capLane;

  // Address and data follow the same two-flop path as the controls.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrS1 <= '0;
      addrS2 <= '0;
      dataS1 <= '0;
      dataS2 <= '0;
    end else begin
      addrS1 <= addrIn;
      addrS2 <= addrS1;
      dataS1 <= dataIn;
      dataS2 <= dataS1;
    end
  end

  // Hold the last sample taken while the write was active.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr <= '0;
      capData <= '0;
      capLane <= '0;
    end else if (strb.capture) begin
      capAddr <= addrS2;
      capData <= dataS2;
      capLane <= strb.capLane;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (strb.commit && capLane[g])
        mem[capAddr] <= capData[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneOe[g]                     <= 1'b0;
        dataOut[g*LANE_W +: LANE_W]   <= '0;
      end else begin
        laneOe[g]                     <= strb.rdLane[g];
        dataOut[g*LANE_W +: LANE_W]   <= strb.rdLane[g] ? mem[addrS2] : '0;
      end
    end
  end

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bytelane_sram_pkg::*;
#(
  parameter int ADDR_W = 10
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic                 ceN,
  input  logic                 weN,
  input  logic                 oeN,
  input  logic                 lbN,
  input  logic                 ubN,
  input  logic [DATA_W-1:0]    dataIn,
  output logic [DATA_W-1:0]    dataOut,
  output logic [NUM_LANES-1:0] laneOe
);

  ctl_t    ctlIn;
  ctl_t    ctlSync;
  strobe_t strb;

  assign ctlIn.ceN  = ceN;
  assign ctlIn.weN  = weN;
  assign ctlIn.oeN  = oeN;
  assign ctlIn.selN = {ubN, lbN};

  bytelane_sram_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctlIn   (ctlIn),
    .ctlSync (ctlSync),
    .strb    (strb)
  );

  bytelane_sram_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .strb    (strb),
    .dataOut (dataOut),
    .laneOe  (laneOe)
  );

endmodule

// File: rtl/bytelane_sram_chk.sv
module bytelane_sram_chk
  import bytelane_sram_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input ctl_t                 ctlSync,
  input logic [DATA_W-1:0]    dataOut,
  input logic [NUM_LANES-1:0] laneOe
);

  // R2: standby drives nothing
  a_r2_standby_hiz: assert property (@(posedge clk) disable iff (!rstN)
    ctlSync.ceN |=> laneOe == '0);

  // R7: write strobe low keeps drivers off
  a_r7_write_hiz: assert property (@(posedge clk) disable iff (!rstN)
    !ctlSync.weN |=> laneOe == '0);

  // R8: output-disable mode
  a_r8_outdis_hiz: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlSync.ceN && ctlSync.weN && ctlSync.oeN) |=> laneOe == '0);

  // R4: driven lanes follow the byte selects in read mode
  a_r4_lane_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlSync.ceN && ctlSync.weN && !ctlSync.oeN) |=> laneOe == ~$past(ctlSync.selN));

  // R9: no selects, no drive
  a_r9_nosel_hiz: assert property (@(posedge clk) disable iff (!rstN)
    (ctlSync.selN == '1) |=> laneOe == '0);

  // R4: undriven lanes read as zero
  for (genvar g = 0; g < NUM_LANES; g++) begin : gZero
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
      !laneOe[g] |-> dataOut[g*LANE_W +: LANE_W] == '0);
  end

endmodule

bind bytelane_sram bytelane_sram_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .ctlSync (ctlSync),
  .dataOut (dataOut),
  .laneOe  (laneOe)
);

// File: tb/sim_bytelane_sram.sv
`timescale 1ns/1ps
module sim_bytelane_sram;

  localparam int AW    = 4;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addrIn;
  logic          ceN, weN, oeN, lbN, ubN;
  logic [15:0]   dataIn;
  logic [15:0]   dataOut;
  logic [1:0]    laneOe;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow [WORDS];

  always #5 clk = ~clk;

  bytelane_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .ceN(ceN), .weN(weN),
    .oeN(oeN), .lbN(lbN), .ubN(ubN), .dataIn(dataIn),
    .dataOut(dataOut), .laneOe(laneOe)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h1357) ^ 16'hA5C3;
  endfunction

  task automatic check(input string req, input logic [1:0] expOe, input logic [15:0] expD);
    checks++;
    if (laneOe !== expOe || dataOut !== expD) begin
      errors++;
      $display("FAIL %s: laneOe=%b dataOut=%h expected laneOe=%b dataOut=%h",
               req, laneOe, dataOut, expOe, expD);
    end
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic c, input logic w,
                       input logic o, input logic l, input logic u, input logic [15:0] d);
    @(negedge clk);
    addrIn = a; ceN = c; weN = w; oeN = o; lbN = l; ubN = u; dataIn = d;
  endtask

  // Results are due on the third rising edge; sample on the next falling edge.
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input string req, input int a, input logic l, input logic u);
    logic [1:0]  eo;
    logic [15:0] ed;
    drive(AW'(a), 1'b0, 1'b1, 1'b0, l, u, 16'h0);
    settle();
    eo = {~u, ~l};
    ed = {eo[1] ? shadow[a][15:8] : 8'h00, eo[0] ? shadow[a][7:0] : 8'h00};
    check(req, eo, ed);
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic l, input logic u,
                    input logic o, input logic ceEnd, input int a2, input logic [15:0] d2);
    drive(AW'(a), 1'b0, 1'b0, o, l, u, d);
    repeat (4) @(posedge clk);
    @(negedge clk);
    addrIn = AW'(a2); dataIn = d2;
    if (ceEnd) ceN = 1'b1; else weN = 1'b1;
    repeat (4) @(posedge clk);
    drive(AW'(a2), 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, d2);
    repeat (2) @(posedge clk);
    if (!l) shadow[a][7:0]  = d[7:0];
    if (!u) shadow[a][15:8] = d[15:8];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; addrIn = '0; ceN = 1; weN = 1; oeN = 1; lbN = 1; ubN = 1; dataIn = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R11 reset", 2'b00, 16'h0000);
    rstN = 1'b1;

    // R1: fill every word, then sweep all lane combinations (R3, R4, R9)
    for (int a = 0; a < WORDS; a++) wr(a, pat(a), 1'b0, 1'b0, 1'b1, 1'b0, a, pat(a));
    for (int a = 0; a < WORDS; a++)
      for (int s = 0; s < 4; s++)
        rd((s == 3) ? "R9 no-select read" : "R1 R3 R4 read", a, s[0], s[1]);

    // R6: single-lane writes
    for (int a = 0; a < WORDS; a++) begin
      if (a % 2 == 1) wr(a, ~pat(a) ^ 16'h00F0, 1'b0, 1'b1, 1'b1, 1'b0, a, 16'h0);
      else            wr(a, ~pat(a) ^ 16'h0F00, 1'b1, 1'b0, 1'b1, 1'b0, a, 16'h0);
    end
    for (int a = 0; a < WORDS; a++) rd("R6 byte write", a, 1'b0, 1'b0);

    // R5: oeN ignored in write mode; R7: no drive while writing
    wr(2, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b0, 2, 16'h1234);
    rd("R5 write oe high", 2, 1'b0, 1'b0);
    drive(4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h4321);
    settle();
    check("R7 write hiz", 2'b00, 16'h0000);
    drive(4'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h4321);
    repeat (4) @(posedge clk);
    drive(4'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h4321);
    repeat (2) @(posedge clk);
    shadow[3] = 16'h4321;
    rd("R5 write oe low", 3, 1'b0, 1'b0);

    // R2: standby ignores write strobe and drives nothing
    drive(4'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hBEEF);
    settle();
    check("R2 standby hiz", 2'b00, 16'h0000);
    drive(4'd5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'hBEEF);
    repeat (4) @(posedge clk);
    rd("R2 standby no write", 5, 1'b0, 1'b0);

    // R9: write with no selects
    wr(6, 16'hDEAD, 1'b1, 1'b1, 1'b1, 1'b0, 6, 16'hDEAD);
    rd("R9 no-select write", 6, 1'b0, 1'b0);

    // R8: output disable
    drive(4'd6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    settle();
    check("R8 output disable", 2'b00, 16'h0000);

    // R10: chip-enable-ended write, data/address change with the end
    wr(7, 16'hC0DE, 1'b0, 1'b0, 1'b0, 1'b1, 8, 16'h7777);
    rd("R10 ce end stored", 7, 1'b0, 1'b0);
    rd("R10 ce end other addr", 8, 1'b0, 1'b0);
    // later we rise with ce high commits nothing
    drive(4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h9999);
    repeat (4) @(posedge clk);
    drive(4'd8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h9999);
    repeat (4) @(posedge clk);
    rd("R10 late we rise", 8, 1'b0, 1'b0);
    // write-enable-ended write with address change at the end
    wr(9, 16'h5A5A, 1'b0, 1'b0, 1'b1, 1'b0, 10, 16'h6666);
    rd("R10 we end stored", 9, 1'b0, 1'b0);
    rd("R10 we end other addr", 10, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule